// File: doc/BRIEF.md
# Transceiver Byte FIFO Pair with Status Count

This block holds the two byte queues that sit between a serial host port and a packet modem. One queue carries bytes toward the transmitter: the host only writes into it and the modem only drains it. The other queue carries received bytes: the modem fills it and the host only reads it. Each queue is 64 bytes deep and is read in show-ahead fashion, so the head byte is always present on the read data output.

For every serial access the host sees a four-bit count. A write access (direction bit low) shows the free space in the transmit queue. A read access (direction bit high) shows the bytes waiting in the receive queue. The count comes from the stored occupancy, so during a write it shows the space before the byte in flight is stored. Flush commands for each queue are obeyed only while the radio state is idle or one of the two FIFO error states. Both queues are emptied when the radio state moves into sleep. A sticky flag marks a drain from an empty transmit queue, and another marks a fill into a full receive queue.

Top module: `dual_fifo_status`

## Requirements
- R1: After reset the transmit queue reports 64 free bytes, the receive queue reports 0 used bytes and both error flags are low; each queue returns its bytes in the order written.
- R2: With `access_read` low, `status_count` shows transmit free space; with `access_read` high, it shows receive bytes used.
- R3: `status_count` saturates at 15 when the selected quantity is above 15.
- R4: `status_count` depends only on stored occupancy, so during a transmit write it shows the free space before that byte is stored; the write that fills the last slot sees a count of 1, and the count reads 0 on the next cycle.
- R5: A flush command is obeyed only when `radio_state` is 1 (idle), 2 (receive overflow) or 3 (transmit underflow); in any other state it has no effect. An obeyed flush empties that queue and wins over a push or pop in the same cycle.
- R6: The cycle in which `radio_state` changes to 0 (sleep) from any other value empties both queues; staying at 0 does not empty them again.
- R7: A transmit pop with the transmit queue empty sets `tx_underflow`, which then stays high until an obeyed transmit flush.
- R8: A receive push into a full receive queue without a pop in the same cycle drops the byte and sets `rx_overflow`, which stays high until an obeyed receive flush; the stored bytes are unchanged.
- R9: A push and a pop in the same cycle on a non-empty queue leave its occupancy unchanged; on a full queue the push is accepted because of the pop and no flag is set.
- R10: A transmit push into a full transmit queue without a pop is ignored and stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_push | input | 1 | Host writes a byte into the transmit queue |
| tx_wdata | input | 8 | Byte written into the transmit queue |
| tx_pop | input | 1 | Modem drains the head byte of the transmit queue |
| tx_rdata | output | 8 | Head byte of the transmit queue |
| rx_push | input | 1 | Modem writes a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads the head byte of the receive queue |
| rx_rdata | output | 8 | Head byte of the receive queue |
| flush_tx_cmd | input | 1 | Request to empty the transmit queue |
| flush_rx_cmd | input | 1 | Request to empty the receive queue |
| radio_state | input | 4 | Current radio state code (0 sleep, 1 idle, 2 receive overflow, 3 transmit underflow) |
| access_read | input | 1 | Direction of the current serial access, high for read |
| status_count | output | 4 | Saturated free or used count for the status byte |
| tx_free | output | 7 | Free slots in the transmit queue |
| rx_used | output | 7 | Bytes held in the receive queue |
| tx_underflow | output | 1 | Sticky transmit underflow flag |
| rx_overflow | output | 1 | Sticky receive overflow flag |

## Verification
On every cycle the assertions check the count's saturation and direction choice, that an obeyed flush or a sleep entry leaves the queue empty on the next cycle, that a refused flush leaves occupancy untouched, the setting and stickiness of both error flags, and that a combined push and pop keeps occupancy. Only the directed scenarios can show byte order through a full wrap of each queue, the pre-write count seen during each write up to the last free slot, that a dropped receive byte does not disturb the stored head, and that a held sleep state does not clear again.

// File: rtl/radio_fifo_pkg.sv
package radio_fifo_pkg;

  localparam int STATE_W = 4;

  localparam logic [STATE_W-1:0] RS_SLEEP  = 4'd0;
  localparam logic [STATE_W-1:0] RS_IDLE   = 4'd1;
  localparam logic [STATE_W-1:0] RS_RX_OVF = 4'd2;
  localparam logic [STATE_W-1:0] RS_TX_UNF = 4'd3;

  localparam int COUNT_W   = 4;
  localparam int COUNT_MAX = (1 << COUNT_W) - 1;

  // Clamp an occupancy value to the four-bit status field.
  function automatic logic [COUNT_W-1:0] sat_count(input int unsigned n);
    if (n > COUNT_MAX) return COUNT_W'(COUNT_MAX);
    return COUNT_W'(n);
  endfunction

  // States in which a flush request is honoured.
  function automatic logic flush_allowed(input logic [STATE_W-1:0] st);
    return (st == RS_IDLE) || (st == RS_RX_OVF) || (st == RS_TX_UNF);
  endfunction

endpackage

// File: rtl/rf_byte_fifo.sv
module rf_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [LVL_W-1:0] level,
  output logic             push_drop,
  output logic             pop_miss
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             empty;
  logic             full;
  logic             pop_ok;
  logic             push_ok;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign empty     = (level == '0);
  assign full      = (level == LVL_W'(DEPTH));
  assign pop_ok    = pop && !empty && !clear;
  assign push_ok   = push && (!full || pop_ok) && !clear;
  assign push_drop = push && !push_ok && !clear;
  assign pop_miss  = pop && empty && !clear;
  assign rdata     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/rf_flush_ctrl.sv
module rf_flush_ctrl
  import radio_fifo_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] radio_state,
  input  logic               flush_tx_cmd,
  input  logic               flush_rx_cmd,
  output logic               tx_flush_ok,
  output logic               rx_flush_ok,
  output logic               sleep_entry,
  output logic               clr_tx,
  output logic               clr_rx
);

  logic [STATE_W-1:0] prev_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_state <= RS_IDLE;
    else        prev_state <= radio_state;
  end

  assign sleep_entry = (radio_state == RS_SLEEP) && (prev_state != RS_SLEEP);
  assign tx_flush_ok = flush_tx_cmd && flush_allowed(radio_state);
  assign rx_flush_ok = flush_rx_cmd && flush_allowed(radio_state);
  assign clr_tx      = tx_flush_ok || sleep_entry;
  assign clr_rx      = rx_flush_ok || sleep_entry;

endmodule

// File: rtl/rf_sticky_flag.sv
module rf_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clear,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (clear) flag <= 1'b0;
    else if (set)   flag <= 1'b1;
  end

endmodule

// File: rtl/dual_fifo_status.sv
module dual_fifo_status
  import radio_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_push,
  input  logic [WIDTH-1:0]   tx_wdata,
  input  logic               tx_pop,
  output logic [WIDTH-1:0]   tx_rdata,
  input  logic               rx_push,
  input  logic [WIDTH-1:0]   rx_wdata,
  input  logic               rx_pop,
  output logic [WIDTH-1:0]   rx_rdata,
  input  logic               flush_tx_cmd,
  input  logic               flush_rx_cmd,
  input  logic [STATE_W-1:0] radio_state,
  input  logic               access_read,
  output logic [COUNT_W-1:0] status_count,
  output logic [LVL_W-1:0]   tx_free,
  output logic [LVL_W-1:0]   rx_used,
  output logic               tx_underflow,
  output logic               rx_overflow
);

  // Named internal events, visible to the bound checker.
  logic             tx_flush_ok;
  logic             rx_flush_ok;
  logic             sleep_entry;
  logic             clr_tx;
  logic             clr_rx;
  logic [LVL_W-1:0] tx_level;
  logic             tx_push_drop;
  logic             tx_pop_miss;
  logic             rx_push_drop;
  logic             rx_pop_miss;
  logic [LVL_W-1:0] count_src;

  rf_flush_ctrl u_flush (
    .clk          (clk),
    .rst_n        (rst_n),
    .radio_state  (radio_state),
    .flush_tx_cmd (flush_tx_cmd),
    .flush_rx_cmd (flush_rx_cmd),
    .tx_flush_ok  (tx_flush_ok),
    .rx_flush_ok  (rx_flush_ok),
    .sleep_entry  (sleep_entry),
    .clr_tx       (clr_tx),
    .clr_rx       (clr_rx)
  );

  rf_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clr_tx),
    .push      (tx_push),
    .wdata     (tx_wdata),
    .pop       (tx_pop),
    .rdata     (tx_rdata),
    .level     (tx_level),
    .push_drop (tx_push_drop),
    .pop_miss  (tx_pop_miss)
  );

  rf_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clr_rx),
    .push      (rx_push),
    .wdata     (rx_wdata),
    .pop       (rx_pop),
    .rdata     (rx_rdata),
    .level     (rx_used),
    .push_drop (rx_push_drop),
    .pop_miss  (rx_pop_miss)
  );

  rf_sticky_flag u_tx_unf (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (tx_pop_miss),
    .clear (tx_flush_ok),
    .flag  (tx_underflow)
  );

  rf_sticky_flag u_rx_ovf (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (rx_push_drop),
    .clear (rx_flush_ok),
    .flag  (rx_overflow)
  );

  assign tx_free      = LVL_W'(DEPTH) - tx_level;
  assign count_src    = access_read ? rx_used : tx_free;
  assign status_count = sat_count(int'(count_src));

endmodule

// File: rtl/rf_fifo_checker.sv
module rf_fifo_checker #(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_push,
  input logic             tx_pop,
  input logic             rx_push,
  input logic             rx_pop,
  input logic             flush_tx_cmd,
  input logic             access_read,
  input logic [3:0]       status_count,
  input logic [LVL_W-1:0] tx_free,
  input logic [LVL_W-1:0] rx_used,
  input logic             tx_underflow,
  input logic             rx_overflow,
  input logic             tx_flush_ok,
  input logic             rx_flush_ok,
  input logic             sleep_entry,
  input logic             clr_tx,
  input logic             clr_rx
);

  localparam logic [LVL_W-1:0] FULLV = LVL_W'(DEPTH);

  assert_levels_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_free <= FULLV) && (rx_used <= FULLV));

  assert_rx_count_direction_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (access_read && rx_used < 15) |-> (status_count == rx_used[3:0]));

  assert_count_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!access_read && tx_free >= 15) |-> (status_count == 4'hF));

  assert_tx_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush_ok |=> (tx_free == FULLV));

  assert_rx_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_ok |=> (rx_used == '0));

  assert_refused_flush_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_tx_cmd && !tx_flush_ok && !sleep_entry && !tx_push && !tx_pop) |=> $stable(tx_free));

  assert_sleep_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_entry |=> (tx_free == FULLV) && (rx_used == '0));

  assert_underflow_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && tx_free == FULLV && !clr_tx) |=> tx_underflow);

  assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_underflow && !tx_flush_ok) |=> tx_underflow);

  assert_no_overflow_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_pop && rx_used == FULLV && !clr_rx) |=> (rx_overflow && rx_used == FULLV));

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overflow && !rx_flush_ok) |=> rx_overflow);

  assert_push_pop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_pop && tx_free != FULLV && !clr_tx) |=> $stable(tx_free));

  assert_full_tx_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && !tx_pop && tx_free == '0 && !clr_tx) |=> (tx_free == '0));

endmodule

bind dual_fifo_status rf_fifo_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_push      (tx_push),
  .tx_pop       (tx_pop),
  .rx_push      (rx_push),
  .rx_pop       (rx_pop),
  .flush_tx_cmd (flush_tx_cmd),
  .access_read  (access_read),
  .status_count (status_count),
  .tx_free      (tx_free),
  .rx_used      (rx_used),
  .tx_underflow (tx_underflow),
  .rx_overflow  (rx_overflow),
  .tx_flush_ok  (tx_flush_ok),
  .rx_flush_ok  (rx_flush_ok),
  .sleep_entry  (sleep_entry),
  .clr_tx       (clr_tx),
  .clr_rx       (clr_rx)
);

// File: tb/tb_dual_fifo_status.sv
module tb_dual_fifo_status;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_push = 1'b0;
  logic [7:0] tx_wdata = '0;
  logic       tx_pop = 1'b0;
  logic [7:0] tx_rdata;
  logic       rx_push = 1'b0;
  logic [7:0] rx_wdata = '0;
  logic       rx_pop = 1'b0;
  logic [7:0] rx_rdata;
  logic       flush_tx_cmd = 1'b0;
  logic       flush_rx_cmd = 1'b0;
  logic [3:0] radio_state = 4'd1;
  logic       access_read = 1'b0;
  logic [3:0] status_count;
  logic [6:0] tx_free;
  logic [6:0] rx_used;
  logic       tx_underflow;
  logic       rx_overflow;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  dual_fifo_status dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_push      (tx_push),
    .tx_wdata     (tx_wdata),
    .tx_pop       (tx_pop),
    .tx_rdata     (tx_rdata),
    .rx_push      (rx_push),
    .rx_wdata     (rx_wdata),
    .rx_pop       (rx_pop),
    .rx_rdata     (rx_rdata),
    .flush_tx_cmd (flush_tx_cmd),
    .flush_rx_cmd (flush_rx_cmd),
    .radio_state  (radio_state),
    .access_read  (access_read),
    .status_count (status_count),
    .tx_free      (tx_free),
    .rx_used      (rx_used),
    .tx_underflow (tx_underflow),
    .rx_overflow  (rx_overflow)
  );

  function automatic logic [7:0] tx_pat(input int k);
    return 8'(k * 7 + 3);
  endfunction

  function automatic logic [7:0] rx_pat(input int k);
    return 8'(k) ^ 8'hA5;
  endfunction

  function automatic int clamp15(input int n);
    return (n > 15) ? 15 : n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All drivers change at a falling edge and hold for one rising edge.
  task automatic do_tx_push(input logic [7:0] b);
    tx_push = 1'b1; tx_wdata = b;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic do_tx_pop();
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic do_rx_push(input logic [7:0] b);
    rx_push = 1'b1; rx_wdata = b;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic do_rx_pop();
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic do_flush(input logic [3:0] st, input bit ftx, input bit frx);
    radio_state = st; flush_tx_cmd = ftx; flush_rx_cmd = frx;
    @(negedge clk);
    flush_tx_cmd = 1'b0; flush_rx_cmd = 1'b0; radio_state = 4'd1;
  endtask

  task automatic t_reset();
    access_read = 1'b0;
    chk("R1 tx_free after reset", tx_free, 64);
    chk("R1 rx_used after reset", rx_used, 0);
    chk("R1 underflow after reset", tx_underflow, 0);
    chk("R1 overflow after reset", rx_overflow, 0);
    chk("R3 status saturated at reset", status_count, 15);
  endtask

  task automatic t_tx_order();
    for (int k = 0; k < 3; k++) do_tx_push(tx_pat(k));
    chk("R1 tx_free after 3 writes", tx_free, 61);
    chk("R3 status with 61 free", status_count, 15);
    for (int k = 0; k < 3; k++) begin
      chk("R1 tx head order", tx_rdata, tx_pat(k));
      do_tx_pop();
    end
    chk("R1 tx_free after drain", tx_free, 64);
    chk("R7 no underflow after exact drain", tx_underflow, 0);
  endtask

  task automatic t_fill_tx();
    access_read = 1'b0;
    for (int k = 0; k < 64; k++) begin
      tx_push = 1'b1; tx_wdata = tx_pat(k);
      #1;
      chk("R4 pre-write status count", status_count, clamp15(64 - k));
      @(negedge clk);
      tx_push = 1'b0;
    end
    chk("R4 status after last slot filled", status_count, 0);
    chk("R1 tx_free full", tx_free, 0);
    do_tx_push(8'hEE);
    chk("R10 write into full tx ignored", tx_free, 0);
    for (int k = 0; k < 64; k++) begin
      chk("R1 tx wrap order", tx_rdata, tx_pat(k));
      do_tx_pop();
    end
    chk("R10 dropped byte not stored", tx_free, 64);
    chk("R7 no underflow after full drain", tx_underflow, 0);
  endtask

  task automatic t_underflow();
    do_tx_pop();
    chk("R7 underflow set by empty pop", tx_underflow, 1);
    chk("R7 tx_free unchanged by empty pop", tx_free, 64);
    do_tx_push(8'h10);
    do_tx_push(8'h20);
    do_flush(4'd6, 1'b1, 1'b0);
    chk("R5 flush refused in state 6 keeps bytes", tx_free, 62);
    chk("R7 underflow survives refused flush", tx_underflow, 1);
    do_flush(4'd1, 1'b1, 1'b0);
    chk("R5 flush obeyed in idle", tx_free, 64);
    chk("R7 underflow cleared by flush", tx_underflow, 0);
  endtask

  task automatic t_rx();
    access_read = 1'b1;
    for (int k = 0; k < 20; k++) do_rx_push(rx_pat(k));
    chk("R1 rx_used after 20", rx_used, 20);
    chk("R3 rx status saturated", status_count, 15);
    for (int k = 0; k < 10; k++) begin
      chk("R1 rx head order", rx_rdata, rx_pat(k));
      do_rx_pop();
    end
    #1;
    chk("R2 read access shows rx used", status_count, 10);
    access_read = 1'b0;
    #1;
    chk("R2 write access shows tx free", status_count, 15);
    access_read = 1'b1;
    do_flush(4'd9, 1'b0, 1'b1);
    chk("R5 rx flush refused in state 9", rx_used, 10);
    do_flush(4'd2, 1'b0, 1'b1);
    chk("R5 rx flush obeyed in rx-overflow state", rx_used, 0);
    #1;
    chk("R2 read access count zero", status_count, 0);
  endtask

  task automatic t_rx_overflow();
    for (int k = 0; k < 64; k++) do_rx_push(rx_pat(k));
    chk("R8 rx full, no flag yet", rx_overflow, 0);
    do_rx_push(8'h11);
    chk("R8 overflow set", rx_overflow, 1);
    chk("R8 rx_used stays full", rx_used, 64);
    chk("R8 head intact after drop", rx_rdata, rx_pat(0));
    do_rx_pop();
    chk("R8 overflow sticky after pop", rx_overflow, 1);
    do_flush(4'd1, 1'b1, 1'b0);
    chk("R8 tx flush leaves rx overflow", rx_overflow, 1);
    do_flush(4'd3, 1'b0, 1'b1);
    chk("R8 overflow cleared by rx flush", rx_overflow, 0);
    chk("R5 rx flush obeyed in tx-underflow state", rx_used, 0);
  endtask

  task automatic t_simul();
    for (int k = 0; k < 5; k++) do_tx_push(tx_pat(k));
    tx_push = 1'b1; tx_wdata = 8'h77; tx_pop = 1'b1;
    @(negedge clk);
    tx_push = 1'b0; tx_pop = 1'b0;
    chk("R9 tx push+pop keeps level", tx_free, 59);
    chk("R9 tx head advanced", tx_rdata, tx_pat(1));
    chk("R9 no underflow", tx_underflow, 0);
    do_flush(4'd1, 1'b1, 1'b0);
    for (int k = 0; k < 64; k++) do_rx_push(rx_pat(k));
    rx_push = 1'b1; rx_wdata = 8'h55; rx_pop = 1'b1;
    @(negedge clk);
    rx_push = 1'b0; rx_pop = 1'b0;
    chk("R9 full rx push+pop keeps level", rx_used, 64);
    chk("R9 full rx push+pop no overflow", rx_overflow, 0);
    chk("R9 rx head advanced", rx_rdata, rx_pat(1));
    do_flush(4'd1, 1'b0, 1'b1);
  endtask

  task automatic t_sleep();
    for (int k = 0; k < 3; k++) do_tx_push(tx_pat(k));
    for (int k = 0; k < 4; k++) do_rx_push(rx_pat(k));
    radio_state = 4'd0;
    @(negedge clk);
    chk("R6 sleep entry empties tx", tx_free, 64);
    chk("R6 sleep entry empties rx", rx_used, 0);
    do_tx_push(8'h42);
    radio_state = 4'd0;
    @(negedge clk);
    chk("R6 held sleep does not clear again", tx_free, 63);
    radio_state = 4'd1;
    do_flush(4'd1, 1'b1, 1'b0);
    chk("R5 final tx flush", tx_free, 64);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_order();
    t_fill_tx();
    t_underflow();
    t_rx();
    t_rx_overflow();
    t_simul();
    t_sleep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule